// File: doc/BRIEF.md
# Program Sequencer with Skip Flush

This block steers program flow for a machine with 14-bit instruction words. It drives the fetch address and registers the word that comes back, which then executes in the following cycle. It decodes the control instructions itself: jumps, subroutine calls, the three kinds of return, no-op, standby and watchdog clear. It keeps return addresses on a small stack.

When an instruction redirects the program counter, the word already fetched is invalid. The block discards that word, so the next cycle runs as a forced no-op. The same happens when the execute unit reports a true skip condition for a skip-type instruction. Jumps, calls, returns and taken skips therefore cost two cycles, and every other instruction costs one.

Standby, watchdog clear and the interrupt-enable set on return-from-interrupt are one-cycle strobes to the neighbouring units.

Top module: `prog_sequencer`

## Requirements
- R1: During reset and in the first cycle after it, the fetch address is 0, the no-op slot flag is high, and the standby, watchdog-clear and interrupt-enable strobes are low.
- R2: A valid instruction that is neither a control transfer nor a taken skip advances the fetch address by one. The next cycle is not a no-op slot.
- R3: A word whose bits 13:12 are 2'b10 is a transfer. Bit 11 = 0 means call, and bit 11 = 1 means jump. Bits 10:0 become the next fetch address, and the following cycle is a no-op slot.
- R4: A call pushes the address that follows it. Return (14'h0008), return-from-interrupt (14'h0009) and return-with-literal (bits 13:10 = 4'b1101) pop that address into the fetch address. Each of them takes two cycles.
- R5: The return stack holds 8 entries and wraps circularly. A ninth nested call overwrites the oldest entry, and the ninth return yields the ninth pushed address again.
- R6: A skip-type word is bits 13:8 = 6'b001011, bits 13:8 = 6'b001111, bits 13:10 = 4'b0110 or bits 13:10 = 4'b0111. If such a word executes with skipTrue high, the fetched word is discarded, the fetch address advances by one, and the next cycle is a no-op slot.
- R7: skipTrue has no effect while a non-skip word executes or while the cycle is a no-op slot.
- R8: Return-from-interrupt raises gieSet for exactly its execute cycle.
- R9: Standby (14'h0063) raises sleepReq, and watchdog clear (14'h0064) raises wdtClrReq, for one cycle and only in a valid slot. No-op words of the form 14'b00_0000_0xx0_0000 raise nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| progData | input | 14 | Program word read combinationally at progAddr |
| skipTrue | input | 1 | Execute unit: skip condition of the executing word is true |
| progAddr | output | 11 | Fetch address (program counter) |
| nopSlot | output | 1 | Current cycle executes as a forced no-op |
| sleepReq | output | 1 | Standby request strobe |
| wdtClrReq | output | 1 | Watchdog clear request strobe |
| gieSet | output | 1 | Set global interrupt enable strobe |

## Verification
Several rules are checked on every cycle:
- a transfer loads its encoded target and is followed by a no-op slot;
- a plain instruction advances the address by one without a flush;
- a taken skip flushes, and a no-op slot never produces a second one;
- an ignored skip leaves the slot valid;
- the request strobes are mutually exclusive and appear only in valid slots.

The contents of the return stack cannot be seen from the ports. Return order and the circular overwrite after eight nested calls therefore show only in the bench's scenarios. The same holds for whole-program cycle counts, which the bench checks by tracing the fetch address cycle by cycle.

// File: rtl/prog_seq_pkg.sv
`timescale 1ns/1ps
package prog_seq_pkg;
  localparam int INSTR_W = 14;
  localparam logic [INSTR_W-1:0] OP_RETURN = 14'h0008;
  localparam logic [INSTR_W-1:0] OP_RETINT = 14'h0009;
  localparam logic [INSTR_W-1:0] OP_STANDBY = 14'h0063;
  localparam logic [INSTR_W-1:0] OP_WDOGCLR = 14'h0064;

  // strobes from control to datapath
  typedef struct packed {
    logic jump;
    logic push;
    logic pop;
  } pcStrobes_t;
endpackage

// File: rtl/prog_seq_ctrl.sv
`timescale 1ns/1ps
module prog_seq_ctrl
  import prog_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] progData,
  input  logic               skipTrue,
  output logic [INSTR_W-1:0] irWord,
  output logic               irValid,
  output pcStrobes_t         strobes,
  output logic               sleepReq,
  output logic               wdtClrReq,
  output logic               gieSet
);
  logic isXfer, isCall, isRet, isSkipOp, doSkip, flush;

  always_comb begin
    isXfer   = irWord[13:12] == 2'b10;
    isCall   = isXfer && !irWord[11];
    isRet    = (irWord == OP_RETURN) || (irWord == OP_RETINT) ||
               (irWord[13:10] == 4'b1101);
    isSkipOp = (irWord[13:8] == 6'b001011) || (irWord[13:8] == 6'b001111) ||
               (irWord[13:10] == 4'b0110) || (irWord[13:10] == 4'b0111);
    doSkip       = irValid && isSkipOp && skipTrue;
    strobes.jump = irValid && isXfer;
    strobes.push = irValid && isCall;
    strobes.pop  = irValid && isRet;
    flush        = strobes.jump || strobes.pop || doSkip;
    sleepReq     = irValid && (irWord == OP_STANDBY);
    wdtClrReq    = irValid && (irWord == OP_WDOGCLR);
    gieSet       = irValid && (irWord == OP_RETINT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irWord  <= '0;
      irValid <= 1'b0;
    end else begin
      irWord  <= progData;
      irValid <= !flush;
    end
  end
endmodule

// File: rtl/prog_seq_path.sv
`timescale 1ns/1ps
module prog_seq_path
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  pcStrobes_t        strobes,
  input  logic [ADDR_W-1:0] jumpTarget,
  output logic [ADDR_W-1:0] pc
);
  localparam int SP_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam logic [SP_W-1:0] SP_LAST = SP_W'(STACK_DEPTH - 1);

  logic [ADDR_W-1:0] stackMem [STACK_DEPTH];
  logic [SP_W-1:0]   sp, spInc, spDec;
  logic [ADDR_W-1:0] pcNext;

  always_comb begin
    spInc = (sp == SP_LAST) ? '0 : sp + 1'b1;
    spDec = (sp == '0) ? SP_LAST : sp - 1'b1;
    if (strobes.jump)     pcNext = jumpTarget;
    else if (strobes.pop) pcNext = stackMem[spDec];
    else                  pcNext = pc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      sp <= '0;
    end else begin
      pc <= pcNext;
      if (strobes.push)     sp <= spInc;
      else if (strobes.pop) sp <= spDec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && strobes.push) stackMem[sp] <= pc;
  end
endmodule

// File: rtl/prog_sequencer.sv
`timescale 1ns/1ps
module prog_sequencer
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int STACK_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] progData,
  input  logic               skipTrue,
  output logic [ADDR_W-1:0]  progAddr,
  output logic               nopSlot,
  output logic               sleepReq,
  output logic               wdtClrReq,
  output logic               gieSet
);
  logic [INSTR_W-1:0] irWord;
  logic               irValid;
  pcStrobes_t         strobes;

  prog_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .progData(progData), .skipTrue(skipTrue),
    .irWord(irWord), .irValid(irValid), .strobes(strobes),
    .sleepReq(sleepReq), .wdtClrReq(wdtClrReq), .gieSet(gieSet)
  );

  prog_seq_path #(.ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH)) u_path (
    .clk(clk), .rst(rst), .strobes(strobes),
    .jumpTarget(irWord[ADDR_W-1:0]), .pc(progAddr)
  );

  assign nopSlot = !irValid;
endmodule

// File: rtl/prog_seq_checker.sv
`timescale 1ns/1ps
module prog_seq_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic [13:0]       irWord,
  input logic              irValid,
  input logic              skipTrue,
  input logic [ADDR_W-1:0] progAddr,
  input logic              nopSlot,
  input logic              sleepReq,
  input logic              wdtClrReq,
  input logic              gieSet
);
  logic xferOp, retOp, skipOp, plainOp;
  always_comb begin
    xferOp  = irWord[13:12] == 2'b10;
    retOp   = irWord == 14'h0008 || irWord == 14'h0009 || irWord[13:10] == 4'b1101;
    skipOp  = irWord[13:8] == 6'b001011 || irWord[13:8] == 6'b001111 ||
              irWord[13:11] == 3'b011;
    plainOp = !xferOp && !retOp && !(skipOp && skipTrue);
  end

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    irValid && xferOp |=> nopSlot && progAddr == $past(irWord[ADDR_W-1:0])); // R3
  AST_PLAIN_INC: assert property (@(posedge clk) disable iff (rst)
    irValid && plainOp |=> !nopSlot && progAddr == ADDR_W'($past(progAddr) + 1'b1)); // R2
  AST_RET_FLUSH: assert property (@(posedge clk) disable iff (rst)
    irValid && retOp |=> nopSlot); // R4
  AST_SKIP_FLUSH: assert property (@(posedge clk) disable iff (rst)
    irValid && skipOp && skipTrue |=> nopSlot && progAddr == ADDR_W'($past(progAddr) + 1'b1)); // R6
  AST_NO_DOUBLE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    nopSlot |=> !nopSlot); // R7
  AST_SKIP_IGNORED: assert property (@(posedge clk) disable iff (rst)
    irValid && skipTrue && !skipOp && !xferOp && !retOp |=> !nopSlot); // R7
  AST_REQ_VALID_SLOT: assert property (@(posedge clk) disable iff (rst)
    (sleepReq || wdtClrReq || gieSet) |-> !nopSlot); // R9
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sleepReq, wdtClrReq, gieSet})); // R9
  AST_GIE_PULSE: assert property (@(posedge clk) disable iff (rst)
    gieSet |=> !gieSet); // R8
endmodule

bind prog_sequencer prog_seq_checker #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rst(rst), .irWord(irWord), .irValid(irValid), .skipTrue(skipTrue),
  .progAddr(progAddr), .nopSlot(nopSlot), .sleepReq(sleepReq),
  .wdtClrReq(wdtClrReq), .gieSet(gieSet)
);

// File: tb/prog_sequencer_test.sv
`timescale 1ns/1ps
module prog_sequencer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic skipTrue = 1'b0;
  logic [13:0] progData;
  logic [10:0] progAddr;
  logic nopSlot, sleepReq, wdtClrReq, gieSet;
  logic [13:0] rom [64];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  always_comb progData = rom[progAddr[5:0]];

  prog_sequencer uut (
    .clk(clk), .rst(rst), .progData(progData), .skipTrue(skipTrue),
    .progAddr(progAddr), .nopSlot(nopSlot), .sleepReq(sleepReq),
    .wdtClrReq(wdtClrReq), .gieSet(gieSet)
  );

  // row: {skip, gie, nop, addr[10:0]}; one row per cycle after reset
  localparam logic [13:0] TRACE [16] = '{
    {1'b0, 1'b0, 1'b1, 11'd0},  {1'b0, 1'b0, 1'b0, 11'd1},
    {1'b0, 1'b0, 1'b0, 11'd2},  {1'b0, 1'b0, 1'b1, 11'd8},
    {1'b0, 1'b0, 1'b0, 11'd9},  {1'b0, 1'b0, 1'b1, 11'd12},
    {1'b0, 1'b1, 1'b0, 11'd13}, {1'b0, 1'b0, 1'b1, 11'd9},
    {1'b0, 1'b0, 1'b0, 11'd10}, {1'b0, 1'b0, 1'b1, 11'd2},
    {1'b1, 1'b0, 1'b0, 11'd3},  {1'b0, 1'b0, 1'b1, 11'd4},
    {1'b0, 1'b0, 1'b0, 11'd5},  {1'b0, 1'b0, 1'b0, 11'd6},
    {1'b0, 1'b0, 1'b1, 11'd5},  {1'b0, 1'b0, 1'b0, 11'd6}
  };

  localparam int WRAP_N = 18;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearRom();
    for (int i = 0; i < 64; i++) rom[i] = 14'h0000;
  endtask

  task automatic doReset();
    skipTrue = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #800000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // trace program: calls, nested returns, taken and untaken skips
    clearRom();
    rom[1]  = 14'h2008;  // call 8
    rom[2]  = 14'h1800;  // bit-test skip (taken)
    rom[3]  = 14'h2814;  // jump 20, must be discarded
    rom[4]  = 14'h0B00;  // decrement skip (not taken)
    rom[5]  = 14'h2805;  // jump 5
    rom[8]  = 14'h200C;  // call 12
    rom[9]  = 14'h0008;  // return
    rom[12] = 14'h0009;  // return from interrupt
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 addr in reset", {21'd0, progAddr}, 0);
    check("R1 nop in reset", {31'd0, nopSlot}, 1);
    doReset();
    check("R1 requests after reset", {29'd0, sleepReq, wdtClrReq, gieSet}, 0);
    for (int k = 0; k < 16; k++) begin
      if (k > 0) @(negedge clk);
      check($sformatf("R2 R3 R4 R6 trace addr c%0d", k), {21'd0, progAddr}, {21'd0, TRACE[k][10:0]});
      check($sformatf("R3 R4 R6 trace nop c%0d", k), {31'd0, nopSlot}, {31'd0, TRACE[k][11]});
      check($sformatf("R8 trace gie c%0d", k), {31'd0, gieSet}, {31'd0, TRACE[k][12]});
      skipTrue = TRACE[k][13];
    end

    // R7 / R9: skipTrue held high over non-skip words; request decode
    clearRom();
    rom[1] = 14'h0060;  // no-op variant
    rom[2] = 14'h0063;  // standby
    rom[3] = 14'h0064;  // watchdog clear
    rom[4] = 14'h0080;  // plain data move
    doReset();
    skipTrue = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check($sformatf("R7 ignored skip addr c%0d", k), {21'd0, progAddr}, k);
      check($sformatf("R7 ignored skip nop c%0d", k), {31'd0, nopSlot}, 0);
      check($sformatf("R9 standby c%0d", k), {31'd0, sleepReq}, {31'd0, k == 3});
      check($sformatf("R9 wdog clear c%0d", k), {31'd0, wdtClrReq}, {31'd0, k == 4});
    end
    skipTrue = 1'b0;

    // R7: skip raised during a flushed slot holding a skip word
    clearRom();
    rom[0] = 14'h2804;  // jump 4
    rom[1] = 14'h0B00;  // decrement skip, lands in flushed slot
    rom[2] = 14'h0063;  // standby, never executed
    doReset();
    @(negedge clk);
    @(negedge clk);
    check("R3 jump target", {21'd0, progAddr}, 4);
    check("R3 flushed slot", {31'd0, nopSlot}, 1);
    skipTrue = 1'b1;
    @(negedge clk);
    check("R7 skip in no-op slot addr", {21'd0, progAddr}, 5);
    check("R7 skip in no-op slot nop", {31'd0, nopSlot}, 0);
    check("R9 no request from flushed word", {31'd0, sleepReq}, 0);
    skipTrue = 1'b0;

    // R5: nine nested calls, then nine returns through the circular stack
    clearRom();
    for (int n = 0; n <= 8; n++) begin
      rom[2*n]   = 14'h2000 | 14'(2*n + 2);  // call 2n+2
      rom[2*n+1] = 14'h0008;                  // return
    end
    rom[18] = 14'h0008;
    doReset();
    begin
      int seen;
      int cyc;
      logic [10:0] expT [WRAP_N];
      for (int i = 0; i < 9; i++) expT[i] = 11'(2*i + 2);
      for (int i = 0; i < 8; i++) expT[9+i] = 11'(17 - 2*i);
      expT[17] = 11'd17;
      seen = 0;
      for (cyc = 1; cyc <= 2*WRAP_N && seen < WRAP_N; cyc++) begin
        @(negedge clk);
        if (nopSlot) begin
          check($sformatf("R5 R4 target %0d", seen), {21'd0, progAddr}, {21'd0, expT[seen]});
          check($sformatf("R4 two-cycle timing %0d", seen), cyc, 2*(seen + 1));
          seen++;
        end
      end
      check("R5 all targets seen", seen, WRAP_N);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule